// File: doc/BRIEF.md
# Frame Address Queue Pair

This block keeps the buffer-address queues that sit between a processor and a small DMA Ethernet MAC. Software hands over empty receive buffers by pushing their addresses into a receive queue. It queues frames for sending by writing a buffer address and then a frame length, and the length write commits the entry. Both queues live in one store of `DEPTH` slots. The transmit queue takes the lowest slots and the receive queue takes the slots directly above it. A configuration write moves the boundary between the two regions.

On the MAC side, the MAC takes the next transmit entry, sends it and then signals completion. It also takes the next free receive buffer and reports the length of the frame it placed there. A status word gives the number of transmit entries still held by hardware, so software can reclaim completed buffers. The same word carries a ready flag for each queue. A descriptor register holds the length of the last received frame and flags a frame longer than the programmed maximum.

Top module: `frame_addr_queues`

## Requirements
- R1: After reset the transmit region holds 12 slots, the receive region holds 52 slots and the maximum frame length is 1600. Both queues are empty, both overflow flags are clear, the receive descriptor is 0 and both MAC-side valid outputs are low.
- R2: `stat_word` carries the transmit in-use count in bits [5:0], transmit-ready in bit 24 and receive-ready in bit 25. All other bits read 0.
- R3: A transmit entry takes two writes. The address write only stages the address and leaves the in-use count unchanged. The length write commits the staged address with that length. The MAC sees committed entries in commit order, with their addresses and lengths.
- R4: The transmit in-use count covers entries that are committed but not yet completed. Transmit-ready is low when this count equals the transmit region size. A commit made while transmit-ready is low is dropped and sets `ovf_tx`, which stays set.
- R5: Taking a transmit entry with `mac_tx_pop` does not change the in-use count. Each `mac_tx_done` lowers the count by one, provided at least one taken entry has not yet completed.
- R6: Receive buffer addresses reach the MAC in push order. Receive-ready is low when the receive region is full. A push made while the region is full is dropped and sets `ovf_rx`, which stays set.
- R7: On `mac_rx_take`, `rx_desc[11:0]` takes the reported length, which includes the 4-byte FCS. `rx_desc[12]` is set when that length exceeds the maximum frame length. `rx_desc[15:13]` read 0.
- R8: A configuration write with transmit size `cfg_split[7:0]` and receive size `cfg_split[15:8]` is accepted only if three conditions hold. The transmit size must be between 1 and 63, the receive size must be at least 1, and the two sizes together must not exceed `DEPTH`. An accepted write loads both sizes and `cfg_max_len`, empties both queues and clears both overflow flags. Any other configuration write has no effect.
- R9: `mac_tx_pop` with no committed entry, `mac_tx_done` with nothing outstanding and `mac_rx_take` with no buffer are all ignored. In particular, the count and `rx_desc` keep their values.
- R10: Queue positions wrap within their region, so the order of entries is kept across the end of each region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_split | input | 16 | Receive size [15:8], transmit size [7:0] |
| cfg_max_len | input | 11 | Maximum frame length loaded with the split |
| rxq_push | input | 1 | Push a receive buffer address |
| rxq_addr | input | AW | Receive buffer address |
| txq_addr_wr | input | 1 | Stage a transmit buffer address |
| txq_addr | input | AW | Transmit buffer address |
| txq_len_wr | input | 1 | Commit the staged entry with a length |
| txq_len | input | 12 | Transmit frame length including FCS |
| stat_word | output | 32 | In-use count and ready flags |
| ovf_tx | output | 1 | Sticky transmit overflow |
| ovf_rx | output | 1 | Sticky receive overflow |
| mac_tx_valid | output | 1 | A committed entry waits for the MAC |
| mac_tx_addr | output | AW | Address of the oldest waiting entry |
| mac_tx_len | output | 12 | Length of the oldest waiting entry |
| mac_tx_pop | input | 1 | MAC takes the waiting entry |
| mac_tx_done | input | 1 | MAC finished sending one entry |
| mac_rx_valid | output | 1 | A free receive buffer is available |
| mac_rx_addr | output | AW | Address of the oldest free buffer |
| mac_rx_take | input | 1 | MAC consumed the buffer |
| mac_rx_len | input | 12 | Received frame length including FCS |
| rx_desc | output | 16 | Last received length and oversize flag |

## Verification
The bench uses the default build: a 64-slot store, 32-bit addresses and a 12/52 split. With these values both full conditions and both overflow paths can be reached within a few hundred cycles. At run time the bench changes the split to 2 transmit and 3 receive slots with a maximum of 100. At that size the transmit pointer wraps after two commits, and the receive region starts at slot 2 rather than slot 12. The bench also issues out-of-range splits and checks that they leave the queues untouched.

// File: rtl/faq_pkg.sv
package faq_pkg;
  // Slot number / size type; wide enough for stores up to 255 slots.
  typedef logic [7:0] qsz_t;

  // Advance a region-relative offset, wrapping at the region size.
  function automatic qsz_t ring_next(qsz_t off, qsz_t size);
    qsz_t nxt;
    nxt = off + 8'd1;
    return (nxt == size) ? 8'd0 : nxt;
  endfunction

  // A split is legal when both regions are non-empty, the transmit
  // region fits the count field and the sum fits the store.
  function automatic logic split_legal(qsz_t tx, qsz_t rx, qsz_t total, qsz_t tx_cap);
    logic [8:0] sum;
    sum = {1'b0, tx} + {1'b0, rx};
    return (tx != 8'd0) && (rx != 8'd0) && (tx <= tx_cap) && (sum <= {1'b0, total});
  endfunction

  // Received length (FCS included) beyond the programmed maximum.
  function automatic logic over_max(logic [11:0] len, logic [10:0] max_len);
    return len > {1'b0, max_len};
  endfunction
endpackage

// File: rtl/faq_ring.sv
module faq_ring
  import faq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  qsz_t size,
  input  logic push_req,
  input  logic push_room,
  input  logic pop_req,
  output logic push_ok,
  output logic pop_ok,
  output qsz_t wr_off,
  output qsz_t rd_off,
  output qsz_t count
);
  assign push_ok = push_req & push_room;
  assign pop_ok  = pop_req & (count != 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off <= '0;
      rd_off <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_off <= '0;
      rd_off <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_off <= ring_next(wr_off, size);
      if (pop_ok)  rd_off <= ring_next(rd_off, size);
      count <= count + {7'd0, push_ok} - {7'd0, pop_ok};
    end
  end
endmodule

// File: rtl/faq_store.sv
module faq_store
  import faq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DW     = 44,
  parameter int RB_W   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wa_en,
  input  qsz_t            wa_idx,
  input  logic [DW-1:0]   wa_data,
  input  logic            wb_en,
  input  qsz_t            wb_idx,
  input  logic [DW-1:0]   wb_data,
  input  qsz_t            ra_idx,
  output logic [DW-1:0]   ra_data,
  input  qsz_t            rb_idx,
  output logic [RB_W-1:0] rb_data
);
  logic [DW-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (wa_en && (wa_idx == qsz_t'(i)))
        slot[i] <= wa_data;
      else if (wb_en && (wb_idx == qsz_t'(i)))
        slot[i] <= wb_data;
    end
  end

  always_comb begin
    ra_data = '0;
    rb_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ra_idx == qsz_t'(i)) ra_data = slot[i];
      if (rb_idx == qsz_t'(i)) rb_data = slot[i][RB_W-1:0];
    end
  end
endmodule

// File: rtl/frame_addr_queues.sv
module frame_addr_queues
  import faq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int AW       = 32,
  parameter int LEN_W    = 12,
  parameter int MAXL_W   = 11,
  parameter int TX_DEF   = 12,
  parameter int MAXL_DEF = 1600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_split,
  input  logic [MAXL_W-1:0] cfg_max_len,
  input  logic              rxq_push,
  input  logic [AW-1:0]     rxq_addr,
  input  logic              txq_addr_wr,
  input  logic [AW-1:0]     txq_addr,
  input  logic              txq_len_wr,
  input  logic [LEN_W-1:0]  txq_len,
  output logic [31:0]       stat_word,
  output logic              ovf_tx,
  output logic              ovf_rx,
  output logic              mac_tx_valid,
  output logic [AW-1:0]     mac_tx_addr,
  output logic [LEN_W-1:0]  mac_tx_len,
  input  logic              mac_tx_pop,
  input  logic              mac_tx_done,
  output logic              mac_rx_valid,
  output logic [AW-1:0]     mac_rx_addr,
  input  logic              mac_rx_take,
  input  logic [LEN_W-1:0]  mac_rx_len,
  output logic [15:0]       rx_desc
);
  localparam int   DW     = AW + LEN_W;
  localparam int   RX_DEF = DEPTH - TX_DEF;
  localparam int   CNT_W  = 6;
  localparam int   TX_CAP = ((DEPTH - 1) < (2**CNT_W - 1)) ? (DEPTH - 1) : (2**CNT_W - 1);
  localparam qsz_t TOTAL  = qsz_t'(DEPTH);

  // Configuration state
  qsz_t              tx_depth, rx_depth;
  logic [MAXL_W-1:0] max_len;
  logic [AW-1:0]     tx_addr_stage;

  // Named internal events (observed by the checker)
  logic cfg_take;
  logic tx_room, rx_room;
  logic tx_commit_ok, tx_pop_ok, tx_done_ok;
  logic rx_push_ok, rx_take_ok;
  qsz_t inflight, tx_used;

  qsz_t tx_wr_off, tx_rd_off, tx_count;
  qsz_t rx_wr_off, rx_rd_off, rx_count;
  qsz_t rx_wr_slot, rx_rd_slot;

  logic [DW-1:0] tx_head;

  assign cfg_take = cfg_wr & split_legal(cfg_split[7:0], cfg_split[15:8], TOTAL, qsz_t'(TX_CAP));
  assign tx_used  = tx_count + inflight;
  assign tx_room  = (tx_used != tx_depth);
  assign rx_room  = (rx_count != rx_depth);
  assign tx_done_ok = mac_tx_done & (inflight != 8'd0) & ~cfg_take;

  faq_ring u_tx_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cfg_take),
    .size      (tx_depth),
    .push_req  (txq_len_wr & ~cfg_take),
    .push_room (tx_room),
    .pop_req   (mac_tx_pop & ~cfg_take),
    .push_ok   (tx_commit_ok),
    .pop_ok    (tx_pop_ok),
    .wr_off    (tx_wr_off),
    .rd_off    (tx_rd_off),
    .count     (tx_count)
  );

  faq_ring u_rx_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cfg_take),
    .size      (rx_depth),
    .push_req  (rxq_push & ~cfg_take),
    .push_room (rx_room),
    .pop_req   (mac_rx_take & ~cfg_take),
    .push_ok   (rx_push_ok),
    .pop_ok    (rx_take_ok),
    .wr_off    (rx_wr_off),
    .rd_off    (rx_rd_off),
    .count     (rx_count)
  );

  // Receive region starts right above the transmit region.
  assign rx_wr_slot = tx_depth + rx_wr_off;
  assign rx_rd_slot = tx_depth + rx_rd_off;

  faq_store #(.DEPTH(DEPTH), .DW(DW), .RB_W(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (tx_commit_ok),
    .wa_idx  (tx_wr_off),
    .wa_data ({txq_len, tx_addr_stage}),
    .wb_en   (rx_push_ok),
    .wb_idx  (rx_wr_slot),
    .wb_data ({{LEN_W{1'b0}}, rxq_addr}),
    .ra_idx  (tx_rd_off),
    .ra_data (tx_head),
    .rb_idx  (rx_rd_slot),
    .rb_data (mac_rx_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_depth      <= qsz_t'(TX_DEF);
      rx_depth      <= qsz_t'(RX_DEF);
      max_len       <= MAXL_W'(MAXL_DEF);
      tx_addr_stage <= '0;
      inflight      <= '0;
      ovf_tx        <= 1'b0;
      ovf_rx        <= 1'b0;
      rx_desc       <= '0;
    end else begin
      if (txq_addr_wr) tx_addr_stage <= txq_addr;
      if (cfg_take) begin
        tx_depth <= cfg_split[7:0];
        rx_depth <= cfg_split[15:8];
        max_len  <= cfg_max_len;
        inflight <= '0;
        ovf_tx   <= 1'b0;
        ovf_rx   <= 1'b0;
      end else begin
        inflight <= inflight + {7'd0, tx_pop_ok} - {7'd0, tx_done_ok};
        if (txq_len_wr && !tx_room) ovf_tx <= 1'b1;
        if (rxq_push && !rx_room)   ovf_rx <= 1'b1;
        if (rx_take_ok)
          rx_desc <= {3'b000, over_max(mac_rx_len, max_len), mac_rx_len};
      end
    end
  end

  assign mac_tx_valid = (tx_count != 8'd0);
  assign mac_tx_addr  = tx_head[AW-1:0];
  assign mac_tx_len   = tx_head[DW-1:AW];
  assign mac_rx_valid = (rx_count != 8'd0);

  assign stat_word = {6'd0, rx_room, tx_room, 18'd0, tx_used[CNT_W-1:0]};
endmodule

// File: rtl/faq_chk.sv
module faq_chk
  import faq_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cfg_take,
  input logic txq_addr_wr,
  input logic txq_len_wr,
  input logic rxq_push,
  input logic mac_tx_done,
  input logic tx_room,
  input logic rx_room,
  input qsz_t tx_used,
  input qsz_t tx_depth,
  input qsz_t rx_count,
  input qsz_t rx_depth,
  input logic ovf_tx,
  input logic ovf_rx
);
  // R4
  tx_used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_used <= tx_depth);
  // R4
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_len_wr && !tx_room && !cfg_take) |=> (tx_used <= $past(tx_used)));
  // R4
  ovf_tx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_tx && !cfg_take) |=> ovf_tx);
  // R5
  tx_used_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mac_tx_done && !cfg_take) |=> (tx_used >= $past(tx_used)));
  // R3
  tx_addr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_addr_wr && !txq_len_wr && !mac_tx_done && !cfg_take) |=> (tx_used == $past(tx_used)));
  // R6
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= rx_depth);
  // R6
  rx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_push && !rx_room && !cfg_take) |=> (rx_count <= $past(rx_count)));
  // R6
  ovf_rx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_rx && !cfg_take) |=> ovf_rx);
  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take |=> (tx_used == 8'd0 && rx_count == 8'd0 && !ovf_tx && !ovf_rx));
endmodule

bind frame_addr_queues faq_chk i_faq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_take    (cfg_take),
  .txq_addr_wr (txq_addr_wr),
  .txq_len_wr  (txq_len_wr),
  .rxq_push    (rxq_push),
  .mac_tx_done (mac_tx_done),
  .tx_room     (tx_room),
  .rx_room     (rx_room),
  .tx_used     (tx_used),
  .tx_depth    (tx_depth),
  .rx_count    (rx_count),
  .rx_depth    (rx_depth),
  .ovf_tx      (ovf_tx),
  .ovf_rx      (ovf_rx)
);

// File: tb/test_frame_addr_queues.sv
`timescale 1ns/1ps
module test_frame_addr_queues;
  localparam logic [3:0] OP_TXA = 4'd1, OP_TXL = 4'd2, OP_RXP = 4'd3,
                         OP_POP = 4'd4, OP_DONE = 4'd5, OP_TAKE = 4'd6;
  localparam int NVEC = 10;
  // {op, arg, expected stat_word after the op}; POP arg = expected head address
  localparam logic [67:0] VEC [NVEC] = '{
    {OP_TXA,  32'h0000_1000, 32'h0300_0000},  // R3 staged only
    {OP_TXL,  32'd64,        32'h0300_0001},  // R3 commit
    {OP_TXA,  32'h0000_2000, 32'h0300_0001},  // R3
    {OP_TXL,  32'd100,       32'h0300_0002},  // R2 R3
    {OP_RXP,  32'h0000_A000, 32'h0300_0002},  // R6
    {OP_POP,  32'h0000_1000, 32'h0300_0002},  // R5 pop keeps count
    {OP_DONE, 32'h0,         32'h0300_0001},  // R5
    {OP_POP,  32'h0000_2000, 32'h0300_0001},  // R3 order
    {OP_DONE, 32'h0,         32'h0300_0000},  // R5
    {OP_DONE, 32'h0,         32'h0300_0000}   // R9 nothing outstanding
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_split = '0;
  logic [10:0] cfg_max_len = '0;
  logic        rxq_push = 1'b0;
  logic [31:0] rxq_addr = '0;
  logic        txq_addr_wr = 1'b0;
  logic [31:0] txq_addr = '0;
  logic        txq_len_wr = 1'b0;
  logic [11:0] txq_len = '0;
  logic [31:0] stat_word;
  logic        ovf_tx, ovf_rx;
  logic        mac_tx_valid;
  logic [31:0] mac_tx_addr;
  logic [11:0] mac_tx_len;
  logic        mac_tx_pop = 1'b0;
  logic        mac_tx_done = 1'b0;
  logic        mac_rx_valid;
  logic [31:0] mac_rx_addr;
  logic        mac_rx_take = 1'b0;
  logic [11:0] mac_rx_len = '0;
  logic [15:0] rx_desc;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  frame_addr_queues i_frame_addr_queues (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_split(cfg_split),
    .cfg_max_len(cfg_max_len), .rxq_push(rxq_push), .rxq_addr(rxq_addr),
    .txq_addr_wr(txq_addr_wr), .txq_addr(txq_addr), .txq_len_wr(txq_len_wr),
    .txq_len(txq_len), .stat_word(stat_word), .ovf_tx(ovf_tx), .ovf_rx(ovf_rx),
    .mac_tx_valid(mac_tx_valid), .mac_tx_addr(mac_tx_addr), .mac_tx_len(mac_tx_len),
    .mac_tx_pop(mac_tx_pop), .mac_tx_done(mac_tx_done), .mac_rx_valid(mac_rx_valid),
    .mac_rx_addr(mac_rx_addr), .mac_rx_take(mac_rx_take), .mac_rx_len(mac_rx_len),
    .rx_desc(rx_desc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [31:0] arg);
    @(negedge clk);
    case (op)
      OP_TXA:  begin txq_addr_wr = 1'b1; txq_addr = arg; end
      OP_TXL:  begin txq_len_wr = 1'b1; txq_len = arg[11:0]; end
      OP_RXP:  begin rxq_push = 1'b1; rxq_addr = arg; end
      OP_POP:  mac_tx_pop = 1'b1;
      OP_DONE: mac_tx_done = 1'b1;
      OP_TAKE: begin mac_rx_take = 1'b1; mac_rx_len = arg[11:0]; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    txq_addr_wr = 1'b0; txq_len_wr = 1'b0; rxq_push = 1'b0;
    mac_tx_pop = 1'b0; mac_tx_done = 1'b0; mac_rx_take = 1'b0;
  endtask

  task automatic do_cfg(input logic [15:0] split, input logic [10:0] maxl);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_split = split; cfg_max_len = maxl;
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
  endtask

  task automatic tx_commit(input logic [31:0] a, input logic [31:0] l);
    do_op(OP_TXA, a);
    do_op(OP_TXL, l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R1 reset state, R2 layout
    check("R1 stat", stat_word, 32'h0300_0000);
    check("R1 ovf", {30'd0, ovf_tx, ovf_rx}, 32'd0);
    check("R1 desc", {16'd0, rx_desc}, 32'd0);
    check("R1 valids", {30'd0, mac_tx_valid, mac_rx_valid}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][67:64] == OP_POP) check("R3 head addr", mac_tx_addr, VEC[v][63:32]);
      do_op(VEC[v][67:64], VEC[v][63:32]);
      check("R2 R5 vector stat", stat_word, VEC[v][31:0]);
    end

    // R4 fill transmit region (12 slots)
    for (int i = 0; i < 12; i++) tx_commit(32'h100 + i, 64 + i);
    check("R4 full stat", stat_word, 32'h0200_000C);
    check("R4 no ovf yet", {31'd0, ovf_tx}, 32'd0);
    tx_commit(32'h1FF, 99);
    check("R4 dropped", stat_word, 32'h0200_000C);
    check("R4 ovf set", {31'd0, ovf_tx}, 32'd1);
    for (int i = 0; i < 12; i++) begin
      check("R3 order addr", mac_tx_addr, 32'h100 + i);
      check("R3 order len", {20'd0, mac_tx_len}, 64 + i);
      do_op(OP_POP, 0);
    end
    check("R5 pop keeps count", stat_word, 32'h0200_000C);
    check("R9 pop on empty valid", {31'd0, mac_tx_valid}, 32'd0);
    for (int i = 0; i < 12; i++) do_op(OP_DONE, 0);
    check("R5 all done", stat_word, 32'h0300_0000);
    check("R4 ovf sticky", {31'd0, ovf_tx}, 32'd1);

    // R6 / R7 receive path; one buffer left from the table
    check("R6 head", mac_rx_addr, 32'h0000_A000);
    do_op(OP_TAKE, 1600);
    check("R7 at max", {16'd0, rx_desc}, 32'h0000_0640);
    for (int i = 0; i < 52; i++) do_op(OP_RXP, 32'h8000 + i);
    check("R6 rx full", stat_word, 32'h0100_0000);
    do_op(OP_RXP, 32'hDEAD);
    check("R6 ovf set", {31'd0, ovf_rx}, 32'd1);
    check("R6 first addr", mac_rx_addr, 32'h8000);
    do_op(OP_TAKE, 1601);
    check("R7 oversize", {16'd0, rx_desc}, 32'h0000_1641);
    for (int i = 1; i < 52; i++) begin
      check("R6 order", mac_rx_addr, 32'h8000 + i);
      do_op(OP_TAKE, 60);
    end
    check("R7 last len", {16'd0, rx_desc}, 32'h0000_003C);
    do_op(OP_TAKE, 99);
    check("R9 take on empty", {16'd0, rx_desc}, 32'h0000_003C);
    check("R6 ovf sticky", {31'd0, ovf_rx}, 32'd1);

    // R8 small split: tx 2, rx 3, max 100
    do_cfg(16'h0302, 11'd100);
    check("R8 flush ovf", {30'd0, ovf_tx, ovf_rx}, 32'd0);
    check("R8 stat", stat_word, 32'h0300_0000);
    tx_commit(32'hA0, 70);
    tx_commit(32'hA1, 71);
    check("R8 tx size 2", stat_word, 32'h0200_0002);
    tx_commit(32'hA2X, 72);
    check("R4 ovf small", {31'd0, ovf_tx}, 32'd1);
    check("R3 head A0", mac_tx_addr, 32'hA0);
    do_op(OP_POP, 0);
    do_op(OP_DONE, 0);
    tx_commit(32'hA3, 73);
    check("R10 wrap count", stat_word, 32'h0200_0002);
    check("R10 head A1", mac_tx_addr, 32'hA1);
    do_op(OP_POP, 0);
    check("R10 wrapped head", mac_tx_addr, 32'hA3);
    check("R10 wrapped len", {20'd0, mac_tx_len}, 32'd73);
    do_op(OP_POP, 0);
    for (int i = 0; i < 3; i++) do_op(OP_RXP, 32'hB0 + i);
    check("R8 rx size 3", stat_word, 32'h0000_0002);
    check("R8 rx base", mac_rx_addr, 32'hB0);
    do_op(OP_TAKE, 101);
    check("R8 new max", {16'd0, rx_desc}, 32'h0000_1065);
    do_op(OP_RXP, 32'hB3);
    do_op(OP_TAKE, 100);
    check("R7 equal max", {16'd0, rx_desc}, 32'h0000_0064);
    do_op(OP_TAKE, 10);
    check("R10 rx wrap head", mac_rx_addr, 32'hB3);

    // R8 illegal splits ignored
    do_cfg(16'h2828, 11'd50);
    check("R8 sum too big", stat_word, 32'h0200_0002);
    check("R8 ovf kept", {31'd0, ovf_tx}, 32'd1);
    do_cfg(16'h0300, 11'd50);
    check("R8 zero tx", stat_word, 32'h0200_0002);
    do_cfg(16'h0140, 11'd50);
    check("R8 tx 64", stat_word, 32'h0200_0002);
    do_cfg(16'h340C, 11'd1600);
    check("R8 restore", stat_word, 32'h0300_0000);
    check("R8 rx flushed", {31'd0, mac_rx_valid}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule